// File: doc/BRIEF.md
# SPI Master with Double-Buffered DMA Pointers

This block is an SPI master that fetches each outgoing byte from memory through a read request port and stores each incoming byte through a write port. The memory addresses come from two pointer registers, one for transmit data and one for receive data. Each pointer register is double-buffered. The transfer length comes from a configuration input. A start task captures both pointers into working copies. The block then raises a one-cycle started event. From that moment software may program the next buffer addresses, and the transfer in flight is not affected. A new transfer can therefore be queued while the current one is still running.

In list mode, each programmed pointer moves forward by the transfer length when a transfer completes. A train of hardware start pulses then walks through consecutive fixed-size records in memory with no software involvement. With list mode off, every start uses the same programmed buffer again. Each completed transfer raises an end event pulse and sets a sticky end flag. A stop task ends a transfer early at the next byte boundary. An optional hardware chip select is held low across the bytes of a transfer.

The memory ports follow valid/ready rules. A read request and a write keep valid high, with address and data unchanged, until ready is seen. The read response has no back-pressure: exactly one response cycle (`rd_rsp_valid` high) is expected for each accepted read request, at any later cycle.

Top module: `spi_dma_master`

## Requirements
- R1: A pointer written after the started event does not change the addresses used by the transfer in progress. The new value is used by the next transfer.
- R2: A start task accepted while idle produces a one-cycle `ev_started` pulse in the following cycle. Byte i of the transfer is read from the captured transmit pointer plus i.
- R3: With `cfg_list_en` high, a completed transfer advances each programmed pointer by the transfer length. A pointer written during that transfer keeps the written value instead.
- R4: With `cfg_list_en` low, the programmed pointers never change by themselves, so a repeated start resends the same buffer.
- R5: With `cfg_cs_en` high, `cs_n` is low from the fetch of the first byte through the store of the last byte, and high otherwise. With `cfg_cs_en` low, `cs_n` stays high.
- R6: A completed transfer gives a one-cycle `ev_end` pulse and sets `end_flag`. Only `end_clr` clears the flag, and a set in the same cycle wins.
- R7: `cfg_len` sets the byte count, from 1 up to 255. A length of 0 gives a started pulse and an end pulse with no memory access and no chip select.
- R8: A start task that arrives while a transfer is running is ignored. It causes no extra started event and does not disturb the bytes moved.
- R9: SPI mode 0, MSB first. `sck` idles low. Received data is sampled on the rising edge and the output bit changes on the falling edge. Each half period of `sck` lasts `cfg_div`+1 clock cycles.
- R10: A stop task during a transfer lets the current byte finish, including its store. The transfer then ends with `cs_n` high, no end event, no flag set and no pointer advance.
- R11: `rd_req_valid` and `wr_valid` stay high with stable address (and data) until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_start | input | 1 | Start task pulse |
| task_stop | input | 1 | Stop task pulse |
| cfg_list_en | input | 1 | Advance pointers by the length after each completed transfer |
| cfg_cs_en | input | 1 | Enable the hardware chip select |
| cfg_div | input | DIVW | SCK half period minus one, in clock cycles |
| cfg_len | input | LW | Transfer length in bytes |
| tx_ptr_wr | input | 1 | Write strobe for the transmit pointer |
| tx_ptr_wdata | input | AW | Transmit pointer write value |
| rx_ptr_wr | input | 1 | Write strobe for the receive pointer |
| rx_ptr_wdata | input | AW | Receive pointer write value |
| tx_ptr_q | output | AW | Programmed transmit pointer readback |
| rx_ptr_q | output | AW | Programmed receive pointer readback |
| end_clr | input | 1 | Clears the sticky end flag |
| ev_started | output | 1 | Pointers captured; next pointers may be written |
| ev_end | output | 1 | Transfer completed |
| end_flag | output | 1 | Sticky end-of-transfer flag |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | Hardware chip select, active low |

## Verification
Some rules are checked by assertions on every cycle. These are: the started pulse follows only a start accepted in idle, the sticky flag rises only after an end pulse, `cs_n` is high and `sck` low outside their active states, and requests hold steady under back-pressure. Other behaviour needs the bench's scenarios with a memory model and an SPI slave model. That covers the byte contents in both directions, the pointer rewrite after the started event, list-mode advance over several records, resending with list mode off, the stop point, and zero and maximum lengths.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_XFER,
    ST_WR,
    ST_FIN
  } xfer_state_e;
endpackage

// File: rtl/spi_dma_ptr.sv
// One pointer channel: a programmed value plus the copy captured at start.
module spi_dma_ptr #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          capture,
  input  logic          advance,
  input  logic          list_en,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] prog_q,
  output logic [AW-1:0] base_q
);
  logic dirty_q;  // software wrote since the last capture

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= '0;
      base_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (capture) begin
        base_q  <= prog_q;
        dirty_q <= 1'b0;
      end
      if (wr_en) begin
        prog_q  <= wr_data;
        dirty_q <= 1'b1;
      end else if (advance && list_en && !dirty_q) begin
        prog_q <= base_q + AW'(len);
      end
    end
  end
endmodule

// File: rtl/spi_dma_shift.sv
// Mode 0 byte engine: sample on rising SCK, shift on falling SCK, MSB first.
module spi_dma_shift #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [DW-1:0]   tx_byte,
  input  logic [DIVW-1:0] div,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            done,
  output logic [DW-1:0]   rx_byte
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic            active_q;
  logic [DW-1:0]   tx_sr, rx_sr;
  logic [BW-1:0]   bit_q;
  logic [DIVW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      bit_q    <= '0;
      tmr_q    <= '0;
      sck      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active_q) begin
        active_q <= 1'b1;
        tx_sr    <= tx_byte;
        bit_q    <= '0;
        tmr_q    <= '0;
        sck      <= 1'b0;
      end else if (active_q) begin
        if (tmr_q == div) begin
          tmr_q <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sr <= {rx_sr[DW-2:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_q == BW'(DW - 1)) begin
              active_q <= 1'b0;
              done     <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_sr <= {tx_sr[DW-2:0], 1'b0};
            end
          end
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  assign mosi    = tx_sr[DW-1];
  assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
  import spi_dma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            task_start,
  input  logic            task_stop,
  input  logic            cfg_list_en,
  input  logic            cfg_cs_en,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [LW-1:0]   cfg_len,
  input  logic            tx_ptr_wr,
  input  logic [AW-1:0]   tx_ptr_wdata,
  input  logic            rx_ptr_wr,
  input  logic [AW-1:0]   rx_ptr_wdata,
  output logic [AW-1:0]   tx_ptr_q,
  output logic [AW-1:0]   rx_ptr_q,
  input  logic            end_clr,
  output logic            ev_started,
  output logic            ev_end,
  output logic            end_flag,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  input  logic            rd_rsp_valid,
  input  logic [7:0]      rd_rsp_data,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [7:0]      wr_data,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n
);
  localparam int NCH = 2;  // channel 0 transmit, channel 1 receive

  xfer_state_e   state_q;
  logic [LW-1:0] idx_q, len_q;
  logic          stop_q;
  logic          accept, last_byte, byte_done, in_bytes;

  logic [NCH-1:0] pw_en;
  logic [AW-1:0]  pw_data [NCH];
  logic [AW-1:0]  prog    [NCH];
  logic [AW-1:0]  base    [NCH];

  assign accept    = (state_q == ST_IDLE) && task_start;
  assign last_byte = (idx_q == len_q - 1'b1);
  assign pw_en     = {rx_ptr_wr, tx_ptr_wr};
  assign pw_data[0] = tx_ptr_wdata;
  assign pw_data[1] = rx_ptr_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_ptr
    spi_dma_ptr #(.AW(AW), .LW(LW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pw_en[g]),
      .wr_data(pw_data[g]),
      .capture(accept),
      .advance(state_q == ST_FIN),
      .list_en(cfg_list_en),
      .len    (len_q),
      .prog_q (prog[g]),
      .base_q (base[g])
    );
  end

  assign tx_ptr_q = prog[0];
  assign rx_ptr_q = prog[1];

  spi_dma_shift #(.DW(8), .DIVW(DIVW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     ((state_q == ST_WAIT) && rd_rsp_valid),
    .tx_byte(rd_rsp_data),
    .div    (cfg_div),
    .miso   (miso),
    .sck    (sck),
    .mosi   (mosi),
    .done   (byte_done),
    .rx_byte(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      len_q      <= '0;
      stop_q     <= 1'b0;
      ev_started <= 1'b0;
      end_flag   <= 1'b0;
    end else begin
      ev_started <= accept;
      if (state_q == ST_FIN)  end_flag <= 1'b1;
      else if (end_clr)       end_flag <= 1'b0;
      if (task_stop && state_q != ST_IDLE && state_q != ST_FIN) stop_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          len_q   <= cfg_len;
          idx_q   <= '0;
          stop_q  <= 1'b0;
          state_q <= (cfg_len == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ:  if (rd_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) state_q <= ST_XFER;
        ST_XFER: if (byte_done)    state_q <= ST_WR;
        ST_WR:   if (wr_ready) begin
          idx_q <= idx_q + 1'b1;
          if (stop_q)         state_q <= ST_IDLE;
          else if (last_byte) state_q <= ST_FIN;
          else                state_q <= ST_REQ;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_bytes     = (state_q == ST_REQ) || (state_q == ST_WAIT) ||
                        (state_q == ST_XFER) || (state_q == ST_WR);
  assign cs_n         = !(cfg_cs_en && in_bytes);
  assign ev_end       = (state_q == ST_FIN);
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_req_addr  = base[0] + AW'(idx_q);
  assign wr_valid     = (state_q == ST_WR);
  assign wr_addr      = base[1] + AW'(idx_q);
endmodule

// File: rtl/spi_dma_master_sva.sv
module spi_dma_master_sva
  import spi_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input xfer_state_e   st,
  input logic          task_start,
  input logic          ev_started,
  input logic          ev_end,
  input logic          end_flag,
  input logic          cs_n,
  input logic          sck,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && task_start) |=> ev_started);  // R2

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_started |-> $past(st == ST_IDLE && task_start));  // R8

  AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> end_flag);  // R6

  AST_FLAG_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(ev_end));  // R6

  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_FIN) |-> cs_n);  // R5

  AST_SCK_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_XFER) |-> !sck);  // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));  // R11

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));  // R11
endmodule

bind spi_dma_master spi_dma_master_sva #(.AW(AW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .st          (state_q),
  .task_start  (task_start),
  .ev_started  (ev_started),
  .ev_end      (ev_end),
  .end_flag    (end_flag),
  .cs_n        (cs_n),
  .sck         (sck),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data)
);

// File: tb/spi_dma_master_tb.sv
`timescale 1ns/1ps
module spi_dma_master_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_start = 0, task_stop = 0, cfg_list_en = 0, cfg_cs_en = 1;
  logic [7:0] cfg_div = 8'd1, cfg_len = 8'd0;
  logic tx_ptr_wr = 0, rx_ptr_wr = 0, end_clr = 0;
  logic [AW-1:0] tx_ptr_wdata = '0, rx_ptr_wdata = '0, tx_ptr_q, rx_ptr_q;
  logic ev_started, ev_end, end_flag;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [7:0] rd_rsp_data = '0, wr_data;
  logic wr_valid, wr_ready = 0, sck, mosi, miso = 0, cs_n;

  always #2.5 clk = ~clk;

  spi_dma_master #(.AW(AW), .LW(8), .DIVW(8)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_val(logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] sl_val(int k);
    return 8'(k * 37 + 11);
  endfunction

  // scoreboard queues filled by the driver, drained by the monitor
  logic [7:0]    exp_mosi[$];
  logic [AW+7:0] exp_wr[$];
  bit sb_on = 1'b1;

  int cyc = 0, n_rd = 0, n_wr = 0, n_started = 0, n_end = 0;
  int n_cslow = 0, cs_viol = 0, half = 0, last_edge = 0;
  int sl_k = 0, sl_bits = 0;
  logic [7:0] sl_sr = '0, sl_rx = '0;
  logic sck_d = 1'b0, rsp_pend = 1'b0;
  logic [AW-1:0] rsp_addr = '0;

  // memory model, SPI slave model and monitors
  always @(negedge clk) begin
    cyc++;
    if (rsp_pend) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = tx_val(rsp_addr);
      rsp_pend     = 1'b0;
    end else rd_rsp_valid = 1'b0;
    rd_req_ready = (cyc % 3) != 1;
    if (rd_req_valid && rd_req_ready) begin
      rsp_pend = 1'b1;
      rsp_addr = rd_req_addr;
      n_rd++;
    end
    wr_ready = (cyc % 4) != 2;
    if (wr_valid && wr_ready) begin
      n_wr++;
      if (sb_on) begin
        if (exp_wr.size() == 0) chk(0, "R2", "unexpected write", int'(wr_addr), 0);
        else begin
          logic [AW+7:0] e;
          e = exp_wr.pop_front();
          chk({wr_addr, wr_data} == e, "R9", "rx store addr/data",
              int'({wr_addr, wr_data}), int'(e));
        end
      end
    end
    if (ev_started) n_started++;
    if (ev_end) n_end++;
    if (!cs_n) n_cslow++;
    if (sck != sck_d) begin
      half = cyc - last_edge;
      last_edge = cyc;
    end
    if (ev_started) begin
      sl_bits = 0;
      sl_sr = sl_val(sl_k);
      miso = sl_sr[7];
    end else if (sck && !sck_d) begin
      if (cfg_cs_en && cs_n) cs_viol++;
      sl_rx = {sl_rx[6:0], mosi};
      sl_bits++;
      if (sl_bits == 8 && sb_on) begin
        if (exp_mosi.size() == 0) chk(0, "R2", "unexpected mosi byte", int'(sl_rx), 0);
        else begin
          logic [7:0] m;
          m = exp_mosi.pop_front();
          chk(sl_rx == m, "R9", "mosi byte MSB first", int'(sl_rx), int'(m));
        end
      end
    end else if (!sck && sck_d) begin
      if (sl_bits == 8) begin
        sl_k++;
        sl_bits = 0;
        sl_sr = sl_val(sl_k);
      end else sl_sr = {sl_sr[6:0], 1'b0};
      miso = sl_sr[7];
    end
    sck_d = sck;
  end

  task automatic expect_xfer(int txb, int rxb, int len);
    for (int i = 0; i < len; i++) begin
      exp_mosi.push_back(tx_val(AW'(txb + i)));
      exp_wr.push_back({AW'(rxb + i), sl_val(sl_k + i)});
    end
  endtask
  task automatic pulse_start();
    @(negedge clk) task_start = 1;
    @(negedge clk) task_start = 0;
  endtask
  task automatic wait_end(int e0);
    while (n_end == e0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic wr_ptrs(int txb, int rxb);
    @(negedge clk) begin
      tx_ptr_wr = 1; tx_ptr_wdata = AW'(txb);
      rx_ptr_wr = 1; rx_ptr_wdata = AW'(rxb);
    end
    @(negedge clk) begin tx_ptr_wr = 0; rx_ptr_wr = 0; end
  endtask
  task automatic run(int txb, int rxb, int len);
    int e0;
    e0 = n_end;
    cfg_len = 8'(len);
    expect_xfer(txb, rxb, len);
    pulse_start();
    wait_end(e0);
    chk(exp_mosi.size() == 0 && exp_wr.size() == 0, "R7", "all bytes moved",
        exp_mosi.size() + exp_wr.size(), 0);
  endtask
  task automatic clear_end();
    @(negedge clk) end_clr = 1;
    @(negedge clk) end_clr = 0;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s0, e0, w0, r0, c0;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1, "R5", "cs_n in reset", cs_n, 1);
    chk(sck == 1'b0 && ev_started == 1'b0, "R9", "sck/started in reset", sck, 0);
    rst_n = 1;
    @(negedge clk);
    chk(end_flag == 1'b0, "R6", "end_flag after reset", end_flag, 0);
    chk(tx_ptr_q == '0, "R4", "tx pointer after reset", int'(tx_ptr_q), 0);

    // basic transfer, list off
    wr_ptrs(16'h10, 16'h80);
    s0 = n_started;
    run(16'h10, 16'h80, 4);
    chk(n_started - s0 == 1, "R2", "one started pulse", n_started - s0, 1);
    chk(end_flag == 1'b1, "R6", "end_flag set", end_flag, 1);
    chk(cs_viol == 0, "R5", "cs low during bits", cs_viol, 0);
    chk(half == 2, "R9", "half period div=1", half, 2);
    clear_end();
    @(negedge clk);
    chk(end_flag == 1'b0, "R6", "end_flag cleared", end_flag, 0);

    // R4: resend same buffer with list mode off
    run(16'h10, 16'h80, 4);
    chk(tx_ptr_q == 16'h10 && rx_ptr_q == 16'h80, "R4", "pointer unchanged",
        int'(tx_ptr_q), 16'h10);

    // R1: rewrite pointer after started, current transfer unaffected
    cfg_len = 8'd3;
    e0 = n_end; s0 = n_started;
    expect_xfer(16'h10, 16'h80, 3);
    pulse_start();
    while (n_started == s0) @(negedge clk);
    wr_ptrs(16'h40, 16'h88);
    wait_end(e0);
    chk(exp_mosi.size() == 0, "R1", "current transfer used old pointer", exp_mosi.size(), 0);
    run(16'h40, 16'h88, 3);
    chk(tx_ptr_q == 16'h40, "R1", "new pointer held", int'(tx_ptr_q), 16'h40);

    // R3: list mode walks records
    cfg_list_en = 1;
    wr_ptrs(16'h20, 16'hA0);
    run(16'h20, 16'hA0, 3);
    chk(tx_ptr_q == 16'h23 && rx_ptr_q == 16'hA3, "R3", "advance after first",
        int'(tx_ptr_q), 16'h23);
    run(16'h23, 16'hA3, 3);
    chk(tx_ptr_q == 16'h26, "R3", "advance after second", int'(tx_ptr_q), 16'h26);

    // R8: start while busy is ignored
    cfg_list_en = 0;
    wr_ptrs(16'h50, 16'h90);
    cfg_len = 8'd4;
    e0 = n_end; s0 = n_started;
    expect_xfer(16'h50, 16'h90, 4);
    pulse_start();
    repeat (12) @(negedge clk);
    pulse_start();
    wait_end(e0);
    repeat (4) @(negedge clk);
    chk(n_started - s0 == 1, "R8", "second start ignored", n_started - s0, 1);
    chk(exp_mosi.size() == 0 && exp_wr.size() == 0, "R8", "bytes intact",
        exp_mosi.size() + exp_wr.size(), 0);

    // R10: stop at a byte boundary
    cfg_list_en = 1;
    wr_ptrs(16'h30, 16'hB0);
    clear_end();
    sb_on = 0;
    cfg_len = 8'd5;
    e0 = n_end; w0 = n_wr;
    pulse_start();
    while (n_wr == w0) @(negedge clk);
    @(negedge clk) task_stop = 1;
    @(negedge clk) task_stop = 0;
    repeat (300) @(negedge clk);
    sb_on = 1;
    chk(n_end == e0 && end_flag == 1'b0, "R10", "no end after stop", n_end - e0, 0);
    chk(n_wr - w0 == 2, "R10", "bytes stored before stop", n_wr - w0, 2);
    chk(cs_n == 1'b1, "R10", "cs released", cs_n, 1);
    chk(tx_ptr_q == 16'h30, "R10", "no pointer advance", int'(tx_ptr_q), 16'h30);

    // R5: chip select disabled
    cfg_list_en = 0;
    cfg_cs_en = 0;
    wr_ptrs(16'h60, 16'hC0);
    c0 = n_cslow;
    run(16'h60, 16'hC0, 2);
    chk(n_cslow == c0, "R5", "cs_n stays high when disabled", n_cslow - c0, 0);
    cfg_cs_en = 1;

    // R7: zero length
    c0 = n_cslow; r0 = n_rd; s0 = n_started; e0 = n_end;
    cfg_len = 8'd0;
    pulse_start();
    wait_end(e0);
    chk(n_rd == r0 && n_cslow == c0, "R7", "zero length no access", n_rd - r0, 0);
    chk(n_started - s0 == 1 && n_end - e0 == 1, "R7", "zero length events",
        n_end - e0, 1);

    // R7: maximum length, list mode, fastest clock
    cfg_list_en = 1;
    cfg_div = 8'd0;
    wr_ptrs(16'h100, 16'h400);
    w0 = n_wr;
    run(16'h100, 16'h400, 255);
    chk(n_wr - w0 == 255, "R7", "255 bytes stored", n_wr - w0, 255);
    chk(tx_ptr_q == 16'h1FF && rx_ptr_q == 16'h4FF, "R3", "advance by 255",
        int'(tx_ptr_q), 16'h1FF);
    chk(half == 1, "R9", "half period div=0", half, 1);

    // R9: slower divider
    cfg_list_en = 0;
    cfg_div = 8'd3;
    wr_ptrs(16'h70, 16'hD0);
    run(16'h70, 16'hD0, 1);
    chk(half == 4, "R9", "half period div=3", half, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule